// File: doc/BRIEF.md
# Transmit Frame Length and Preamble Gate

This block sits between a single transmit buffer and a byte-stream transmitter. The host first writes a complete frame into the buffer: seven `0x55` bytes, then `0xD5`, then the payload, then four trailing check bytes. It then writes the total byte count to the count register. A write with a nonzero count starts a check. The block tests the count against a lower and an upper bound. It then reads the eight leading buffer bytes one at a time and compares each with its expected value.

If every check passes, the block streams the bytes between the leading eight and the trailing four onto a valid/ready byte output. It marks the final byte, clears the count register and pulses the interrupt. If any check fails, the block sends nothing, keeps the written count and still pulses the interrupt. The host can therefore read the count register to tell a sent frame (zero) from a refused one (its own value).

Top module: `tx_frame_gate`

## Requirements
- R1: After reset the count register reads 0, `out_valid` is 0 and `tx_done_irq` is 0.
- R2: A count write with a nonzero value while idle starts processing. A write of zero stores 0, starts nothing, emits no bytes and raises no interrupt.
- R3: A count below 64 is refused. No byte is emitted and the count register keeps the written value.
- R4: A count above 1530 is refused in the same way, while 1530 itself is accepted.
- R5: The frame is refused unless buffer offsets 0 to 6 each hold `0x55` and offset 7 holds `0xD5`. A mismatch at any one of these offsets refuses it, and the count register is kept.
- R6: An accepted count N emits exactly N−12 bytes, equal to buffer offsets 8 through N−5 in ascending order.
- R7: `out_last` is 1 on the final emitted byte and 0 on every other byte.
- R8: After an accepted frame has been fully emitted, the count register reads 0.
- R9: Every processed write raises `tx_done_irq` high for exactly one cycle. For a sent frame this follows the last byte's handshake; for a refused frame it is raised whether or not bytes were emitted.
- R10: Count writes while a frame is being processed are ignored. The register value and the emitted bytes are unaffected, and no extra interrupt occurs.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | 16 | Value written to the count register |
| cnt_value | output | 16 | Current count register contents |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | 11 | Buffer byte address |
| buf_rd_data | input | 8 | Buffer byte, valid one cycle after the request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |
| tx_done_irq | output | 1 | One-cycle pulse when processing ends |

## Verification
The count is swept across every value from 1 to 90. It is also tried at the values around the upper bound and at very large values. This separates the refusal paths from streams whose lengths differ by one byte, so an off-by-one in a bound or in the tail trim shows up. The leading-byte check is tried with one wrong byte at each of the eight offsets, including a swap of `0x55` and `0xD5`; this shows that every offset is compared against the right constant. Three downstream ready patterns (always ready, two of three cycles, two of five cycles) test that the output holds steady under stalls. A write during streaming and a write of zero test that the register ignores both.

// File: rtl/tfg_pkg.sv
// Package: shared controller state type for the transmit frame gate.
// Assumes: used by tfg_ctrl only; encoding is free.
package tfg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LIMIT,
        ST_PRE_RD,
        ST_PRE_CMP,
        ST_SEND_RD,
        ST_SEND_LD,
        ST_SEND_WAIT,
        ST_DONE_OK,
        ST_DONE_BAD
    } tfg_state_e;
endpackage

// File: rtl/tfg_count_reg.sv
// Module: count register with write filtering.
// Holds the host-written byte count, ignores writes while busy,
// clears on a successful send. Assumes clear is only asserted while busy.
module tfg_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             busy,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic             start
);
    logic accept;

    // Purpose: a write is taken only when no frame is in progress.
    always_comb accept = wr_en && !busy;

    // Purpose: a taken nonzero write launches processing.
    always_comb start = accept && (wr_data != '0);

    // Purpose: register update on reset, taken write or success clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= wr_data;
        else if (clear)
            cnt_q <= '0;
    end

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |=> (cnt_q == $past(cnt_q)));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !wr_en) |=> (cnt_q == '0));
endmodule

// File: rtl/tfg_out_stage.sv
// Module: single-entry output register for the byte stream.
// Loads one byte when empty, holds it until the downstream handshake.
// Assumes load is only asserted while the stage is empty.
module tfg_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_last,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          last,
    output logic          fire
);
    // Purpose: handshake indicator for the controller.
    always_comb fire = valid && ready;

    // Purpose: hold or replace the presented byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            last  <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            last  <= load_last;
        end else if (fire) begin
            valid <= 1'b0;
            last  <= 1'b0;
        end
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(last)));

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/tfg_ctrl.sv
// Module: sequencing controller.
// Checks the count bounds, compares the leading bytes one per two cycles,
// then fetches and hands over payload bytes one at a time.
// Assumes buffer read data arrives one cycle after the request.
module tfg_ctrl
    import tfg_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          ADDR_W   = 11,
    parameter int          MIN_LEN  = 64,
    parameter int          MAX_LEN  = 1530,
    parameter int          PRE_LEN  = 8,
    parameter int          FCS_LEN  = 4,
    parameter logic [7:0]  PRE_BYTE = 8'h55,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [7:0]        rd_data,
    input  logic              out_fire,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load,
    output logic              load_last,
    output logic              busy,
    output logic              clear,
    output logic              irq
);
    localparam logic [CNT_W-1:0]  MIN_C    = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0]  MAX_C    = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0]  TAIL_C   = CNT_W'(FCS_LEN + 1);
    localparam logic [ADDR_W-1:0] PRE_LAST = ADDR_W'(PRE_LEN - 1);
    localparam logic [ADDR_W-1:0] BODY_0   = ADDR_W'(PRE_LEN);

    tfg_state_e        state_q, state_d;
    logic [ADDR_W-1:0] idx_q, idx_d;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        expect_byte;
    logic              in_range;

    // Purpose: offset of the last byte to send (before the trailing check bytes).
    always_comb last_addr = ADDR_W'(cnt_q - TAIL_C);

    // Purpose: count bound test.
    always_comb in_range = (cnt_q >= MIN_C) && (cnt_q <= MAX_C);

    // Purpose: expected leading byte for the current compare offset.
    always_comb expect_byte = (idx_q == PRE_LAST) ? SFD_BYTE : PRE_BYTE;

    // Purpose: next-state and index selection.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LIMIT;
            ST_LIMIT: begin
                idx_d   = '0;
                state_d = in_range ? ST_PRE_RD : ST_DONE_BAD;
            end
            ST_PRE_RD: state_d = ST_PRE_CMP;
            ST_PRE_CMP: begin
                if (rd_data != expect_byte) begin
                    state_d = ST_DONE_BAD;
                end else if (idx_q == PRE_LAST) begin
                    idx_d   = BODY_0;
                    state_d = ST_SEND_RD;
                end else begin
                    idx_d   = idx_q + 1'b1;
                    state_d = ST_PRE_RD;
                end
            end
            ST_SEND_RD: state_d = ST_SEND_LD;
            ST_SEND_LD: state_d = ST_SEND_WAIT;
            ST_SEND_WAIT: begin
                if (out_fire) begin
                    if (idx_q == last_addr) begin
                        state_d = ST_DONE_OK;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_SEND_RD;
                    end
                end
            end
            ST_DONE_OK:  state_d = ST_IDLE;
            ST_DONE_BAD: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Purpose: state and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Purpose: output decode from the registered state.
    always_comb begin
        rd_en     = (state_q == ST_PRE_RD) || (state_q == ST_SEND_RD);
        rd_addr   = idx_q;
        load      = (state_q == ST_SEND_LD);
        load_last = (state_q == ST_SEND_LD) && (idx_q == last_addr);
        busy      = (state_q != ST_IDLE);
        clear     = (state_q == ST_DONE_OK);
        irq       = (state_q == ST_DONE_OK) || (state_q == ST_DONE_BAD);
    end

    // R9
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3
    ok_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE_OK) |-> in_range);

    // R6
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_RD) |-> (idx_q >= BODY_0 && idx_q <= last_addr));

    // R2
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tx_frame_gate.sv
// Module: top level of the transmit frame gate.
// Wires the count register, the controller and the output stage.
// Assumes a buffer with one-cycle read latency and a valid/ready sink.
module tx_frame_gate #(
    parameter int          CNT_W    = 16,
    parameter int          ADDR_W   = 11,
    parameter int          MIN_LEN  = 64,
    parameter int          MAX_LEN  = 1530,
    parameter int          PRE_LEN  = 8,
    parameter int          FCS_LEN  = 4,
    parameter logic [7:0]  PRE_BYTE = 8'h55,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr_en,
    input  logic [CNT_W-1:0]  cnt_wr_data,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              tx_done_irq
);
    logic start, busy, clear, load, load_last, fire;

    tfg_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .busy    (busy),
        .clear   (clear),
        .cnt_q   (cnt_value),
        .start   (start)
    );

    tfg_ctrl #(
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .MIN_LEN  (MIN_LEN),
        .MAX_LEN  (MAX_LEN),
        .PRE_LEN  (PRE_LEN),
        .FCS_LEN  (FCS_LEN),
        .PRE_BYTE (PRE_BYTE),
        .SFD_BYTE (SFD_BYTE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_q     (cnt_value),
        .rd_data   (buf_rd_data),
        .out_fire  (fire),
        .rd_en     (buf_rd_en),
        .rd_addr   (buf_rd_addr),
        .load      (load),
        .load_last (load_last),
        .busy      (busy),
        .clear     (clear),
        .irq       (tx_done_irq)
    );

    tfg_out_stage #(.DW(8)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (buf_rd_data),
        .load_last (load_last),
        .ready     (out_ready),
        .valid     (out_valid),
        .data      (out_data),
        .last      (out_last),
        .fire      (fire)
    );

    // R7
    last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: tb/sim_tx_frame_gate.sv
module sim_tx_frame_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr_en = 1'b0;
    logic [15:0] cnt_wr_data = '0;
    logic [15:0] cnt_value;
    logic        buf_rd_en;
    logic [10:0] buf_rd_addr;
    logic [7:0]  buf_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;
    logic        tx_done_irq;

    logic [7:0]  mem [0:2047];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ready_mode = 0;
    int rx_n = 0, exp_n = 0, data_err = 0, last_cnt = 0, last_err = 0;
    int irq_cnt = 0, hold_err = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_d = '0;
    logic       prev_l = 1'b0;

    always #10 clk = ~clk;

    tx_frame_gate u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_data (cnt_wr_data),
        .cnt_value   (cnt_value),
        .buf_rd_en   (buf_rd_en),
        .buf_rd_addr (buf_rd_addr),
        .buf_rd_data (buf_rd_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_last    (out_last),
        .tx_done_irq (tx_done_irq)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // buffer model with one-cycle read latency
    initial forever begin
        @(posedge clk);
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
    end

    // ready pattern driver, cycle counter, watchdog
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        case (ready_mode)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = (cyc % 5) < 2;
            default: out_ready = 1'b1;
        endcase
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        if (prev_stall) begin
            if (!out_valid || out_data != prev_d || out_last != prev_l) hold_err++;
        end
        prev_stall = out_valid && !out_ready;
        prev_d = out_data;
        prev_l = out_last;
        if (out_valid && out_ready) begin
            if (out_data != mem[(8 + rx_n) % 2048]) data_err++;
            if (out_last) begin
                last_cnt++;
                if (rx_n != exp_n - 1) last_err++;
            end
            rx_n++;
        end
        if (tx_done_irq) irq_cnt++;
    end

    task automatic fill(input int seed, input int bad_idx, input logic [7:0] bad_val);
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 13 + seed * 7 + 1) & 255);
        for (int i = 0; i < 7; i++) mem[i] = 8'h55;
        mem[7] = 8'hD5;
        if (bad_idx >= 0) mem[bad_idx] = bad_val;
    endtask

    task automatic write_cnt(input int v);
        @(negedge clk);
        cnt_wr_en = 1'b1;
        cnt_wr_data = 16'(v);
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    // one transaction; mid_write >= 0 issues a second write while busy
    task automatic run(input int cnt, input int bad_idx, input logic [7:0] bad_val,
                       input int mode, input int mid_write);
        bit ok;
        int lim;
        ok = (cnt >= 64) && (cnt <= 1530) && (bad_idx < 0);
        fill(cnt, bad_idx, bad_val);
        ready_mode = mode;
        exp_n = ok ? cnt - 12 : 0;
        rx_n = 0; data_err = 0; last_cnt = 0; last_err = 0; irq_cnt = 0; hold_err = 0;
        write_cnt(cnt);
        if (mid_write >= 0) begin
            repeat (20) @(negedge clk);
            cnt_wr_en = 1'b1;
            cnt_wr_data = 16'(mid_write);
            @(negedge clk);
            cnt_wr_en = 1'b0;
        end
        lim = 0;
        while (irq_cnt == 0 && lim < cnt * 8 + 200) begin
            @(negedge clk);
            lim++;
        end
        repeat (4) @(negedge clk);
        if (cnt < 64)
            chk(cnt_value == 16'(cnt) && rx_n == 0, "R3 short count refused", rx_n, 0);
        else if (cnt > 1530)
            chk(cnt_value == 16'(cnt) && rx_n == 0, "R4 long count refused", rx_n, 0);
        else if (bad_idx >= 0)
            chk(cnt_value == 16'(cnt) && rx_n == 0, "R5 bad leading byte refused", rx_n, 0);
        else begin
            chk(rx_n == exp_n, "R6 byte count", rx_n, exp_n);
            chk(data_err == 0, "R6 byte contents", data_err, 0);
            chk(last_cnt == 1 && last_err == 0, "R7 last marker", last_cnt + last_err * 100, 1);
            chk(cnt_value == 0, "R8 count cleared", int'(cnt_value), 0);
            chk(hold_err == 0, "R11 stall hold", hold_err, 0);
            if (mid_write >= 0)
                chk(rx_n == exp_n && cnt_value == 0, "R10 busy write ignored", int'(cnt_value), 0);
        end
        chk(irq_cnt == 1, "R9 one interrupt pulse", irq_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cnt_value == 0, "R1 count after reset", int'(cnt_value), 0);
        chk(!out_valid, "R1 valid after reset", int'(out_valid), 0);
        chk(!tx_done_irq, "R1 irq after reset", int'(tx_done_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // count sweep across the lower bound
        for (int c = 1; c <= 90; c++) run(c, -1, 8'h00, c % 3, -1);
        // upper bound and very large values
        run(1529, -1, 8'h00, 0, -1);
        run(1530, -1, 8'h00, 0, -1);
        run(1531, -1, 8'h00, 0, -1);
        run(2047, -1, 8'h00, 0, -1);
        run(65535, -1, 8'h00, 0, -1);
        // one wrong leading byte at each offset
        for (int k = 0; k < 8; k++) begin
            run(100, k, (k == 7) ? 8'h55 : 8'hD5, 1, -1);
            run(100, k, 8'h00, 2, -1);
        end
        // write while busy (R10)
        run(200, -1, 8'h00, 2, 77);
        run(70, -1, 8'h00, 0, 5);

        // zero write (R2): leave a refused value, then write zero
        run(10, -1, 8'h00, 0, -1);
        irq_cnt = 0; rx_n = 0;
        write_cnt(0);
        repeat (30) @(negedge clk);
        chk(cnt_value == 0, "R2 zero write stores zero", int'(cnt_value), 0);
        chk(irq_cnt == 0 && rx_n == 0, "R2 zero write starts nothing", irq_cnt + rx_n, 0);
        // nonzero write starts processing after the zero write
        run(64, -1, 8'h00, 1, -1);
        chk(cnt_value == 0, "R2 nonzero write processed", int'(cnt_value), 0);

        summary();
    end
endmodule